// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a clocked host and an external 1M x16 pseudo-static RAM that has an asynchronous SRAM-style interface. The host hands over one request at a time through a valid/ready handshake. A request carries a 20-bit word address, 16 bits of write data, a direction bit and a two-bit byte mask. The controller then runs the active-low strobes of the memory (chip enable, output enable, write enable, upper and lower byte enables). It also controls the enable of its own data-bus drivers and returns read data with a one-cycle valid pulse.

The memory hides its own refresh, so every access is closed by raising chip enable. The controller never leaves chip enable low longer than a parameterised cap. It keeps output enable high when a write address is first presented, so that the device does not take the access for a read. Every minimum and maximum is a parameter counted in controller clock cycles. The parameters are rounded up from the nanosecond figures at the chosen clock period. With the defaults at an 8 ns clock the values are: access 9, cycle 10, write pulse 10, write recovery 2, chip-enable high gap 2, output float 3, chip-enable-low cap 125.

The state machine has six states:
- `ST_IDLE`: all strobes high. The block is ready when the gap rule allows.
- `ST_RD_ACC`: the read access wait.
- `ST_RD_HOLD`: pads the read to the minimum cycle time, with output enable raised.
- `ST_WR_SET`: one cycle with the address presented, chip enable low and every other strobe high.
- `ST_WR_PULSE`: write enable and the selected byte enables low, with data driven.
- `ST_WR_REC`: chip enable and write enable high, address and data still held.

The transitions are:
- `ST_IDLE` to `ST_RD_ACC` on an accepted read.
- `ST_IDLE` to `ST_WR_SET` on an accepted write.
- Each other state advances when its cycle counter expires:
  - `ST_RD_ACC` to `ST_RD_HOLD`, which returns to `ST_IDLE`.
  - `ST_WR_SET` to `ST_WR_PULSE`, then to `ST_WR_REC`, which returns to `ST_IDLE`.

Top module: `psram_async_ctrl`

## Requirements
- R1: During and right after reset, all five memory strobes are high, the data drivers are off, `rsp_valid` is low and `req_ready` is high.
- R2: A read holds chip enable and output enable low, write enable high, and the byte enables low as selected. `req_be[0]` selects bits 7..0 (`mem_lb_n`) and `req_be[1]` selects bits 15..8 (`mem_ub_n`). The bus is sampled at the clock edge ACC_CYC edges after the accepting edge. `rsp_valid` is high for exactly one cycle, right after that sample.
- R3: In returned read data, a lane whose byte-enable bit is 0 reads as zero.
- R4: Output enable stays low for exactly ACC_CYC cycles of a read. Chip enable stays low for at least CYC_CYC cycles in every access.
- R5: A write shows one cycle with chip enable low and write and byte enables high. Then write enable and only the selected byte enables stay low for exactly WP_CYC cycles, with the data drivers on throughout.
- R6: Write enable and chip enable rise on the same edge. Address and driven data then stay unchanged for max(REC_CYC, CYC_CYC-WP_CYC-1) cycles, after which the drivers turn off.
- R7: Between two accesses, chip enable is high for at least CPH_CYC+1 cycles.
- R8: When a write follows a read, chip enable is high for at least max(CPH_CYC,HZ_CYC)+1 cycles between them. The data drivers are never on while output enable is low.
- R9: Output enable is high in the first chip-enable-low cycle of every write and whenever write enable falls.
- R10: No chip-enable-low interval exceeds CEMAX_CYC cycles.
- R11: `req_ready` is high only while idle, and a request is taken on a clock edge with `req_valid` and `req_ready` both high. Changes to the request inputs after acceptance do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte select, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Data to the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | 16 | Data from the bus |

## Verification
The hardest case to reach from the ports is the read-to-write turnaround. Here the extra float wait decides whether `req_ready` rises, and a wrong gap shows up only as a short chip-enable-high run. The bench reaches it by issuing a write the moment a read's data has returned, both in directed pairs and often within the random mix. A cycle monitor measures every strobe run and compares it with the rounded-up nanosecond rules. The bench's memory model returns valid data only once the access wait has fully elapsed, and it puts junk on unselected lanes. An early sample, or a lane that is not masked, therefore corrupts the data compared against the bench's shadow copy.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_HOLD  = 3'd2,
        ST_WR_SET   = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_REC   = 3'd5
    } psc_state_e;

    function automatic int unsigned psc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/psc_gap_guard.sv
module psc_gap_guard #(
    parameter int unsigned CPH_CYC  = 2,
    parameter int unsigned TURN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic accept,
    input  logic req_write,
    output logic gap_ok
);

    localparam int unsigned CW = $clog2(TURN_CYC + 1) + 1;

    logic [CW-1:0] hi_cnt_q;
    logic          last_rd_q;
    logic [CW-1:0] need;

    // cycles chip enable has been high, saturating at the longest rule
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt_q <= CW'(TURN_CYC);
        else if (!ce_n)
            hi_cnt_q <= '0;
        else if (hi_cnt_q < CW'(TURN_CYC))
            hi_cnt_q <= hi_cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_rd_q <= 1'b0;
        else if (accept)
            last_rd_q <= !req_write;
    end

    assign need   = (last_rd_q && req_write) ? CW'(TURN_CYC) : CW'(CPH_CYC);
    assign gap_ok = (hi_cnt_q >= need);

    assert_ce_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> ($past(hi_cnt_q) >= CW'(CPH_CYC)));

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce_n) && $past(req_write) && $past(last_rd_q)) |-> ($past(hi_cnt_q) >= CW'(TURN_CYC)));

endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
    import psc_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned ACC_CYC  = 9,
    parameter int unsigned RDH_CYC  = 1,
    parameter int unsigned WP_CYC   = 10,
    parameter int unsigned WREC_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             idle,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             be_act,
    output logic             drive_en,
    output logic             capture
);

    psc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SET;
                        tmr_val = '0;
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    state_d  = ST_RD_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RDH_CYC - 1);
                end
            end
            ST_RD_HOLD: begin
                if (tmr_expired)
                    state_d = ST_IDLE;
            end
            ST_WR_SET: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WREC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (tmr_expired)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        ce_n     = 1'b1;
        oe_n     = 1'b1;
        we_n     = 1'b1;
        be_act   = 1'b0;
        drive_en = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_RD_ACC: begin
                ce_n    = 1'b0;
                oe_n    = 1'b0;
                be_act  = 1'b1;
                capture = tmr_expired;
            end
            ST_RD_HOLD: ce_n = 1'b0;
            ST_WR_SET:  ce_n = 1'b0;
            ST_WR_PULSE: begin
                ce_n     = 1'b0;
                we_n     = 1'b0;
                be_act   = 1'b1;
                drive_en = 1'b1;
            end
            ST_WR_REC: drive_en = 1'b1;
            default: idle = 1'b0;
        endcase
    end

    assert_wr_oe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> (oe_n && $past(oe_n)));

    assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    assert_we_ce_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> $rose(ce_n));

endmodule

// File: rtl/psc_datapath.sv
module psc_datapath #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic              be_act,
    input  logic              drive_en,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int unsigned LANES  = 2;
    localparam int unsigned LANE_W = DATA_W / LANES;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [LANES-1:0]  strobe_n;
    logic              valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= capture;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] rd_lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_lane_q <= '0;
            else if (capture)
                rd_lane_q <= be_q[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
        end
        assign rsp_rdata[g*LANE_W +: LANE_W] = rd_lane_q;
        assign strobe_n[g] = !(be_act && be_q[g]);
    end

    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign mem_dq_oe = drive_en;
    assign mem_lb_n  = strobe_n[0];
    assign mem_ub_n  = strobe_n[1];
    assign rsp_valid = valid_q;

    assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> ($stable(mem_addr) && $stable(mem_dq_o)));

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ACC_CYC   = 9,
    parameter int unsigned CYC_CYC   = 10,
    parameter int unsigned WP_CYC    = 10,
    parameter int unsigned REC_CYC   = 2,
    parameter int unsigned CPH_CYC   = 2,
    parameter int unsigned HZ_CYC    = 3,
    parameter int unsigned CEMAX_CYC = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int unsigned RDH_CYC  = (CYC_CYC > ACC_CYC) ? (CYC_CYC - ACC_CYC) : 1;
    localparam int unsigned WREC_CYC = (CYC_CYC > WP_CYC + 1 + REC_CYC) ? (CYC_CYC - WP_CYC - 1) : REC_CYC;
    localparam int unsigned TURN_CYC = psc_max(CPH_CYC, HZ_CYC);
    localparam int unsigned CNT_MAX  = psc_max(psc_max(ACC_CYC, WP_CYC), psc_max(RDH_CYC, WREC_CYC));
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
    localparam int unsigned CR_W     = $clog2(CEMAX_CYC + 2);

    logic             accept;
    logic             idle;
    logic             gap_ok;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             be_act;
    logic             drive_en;
    logic             capture;
    logic [CR_W-1:0]  ce_run_q;

    assign req_ready = idle && gap_ok;
    assign accept    = req_valid && req_ready;

    psc_fsm #(
        .CNT_W   (CNT_W),
        .ACC_CYC (ACC_CYC),
        .RDH_CYC (RDH_CYC),
        .WP_CYC  (WP_CYC),
        .WREC_CYC(WREC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .idle       (idle),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .be_act     (be_act),
        .drive_en   (drive_en),
        .capture    (capture)
    );

    psc_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    psc_gap_guard #(
        .CPH_CYC (CPH_CYC),
        .TURN_CYC(TURN_CYC)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (mem_ce_n),
        .accept   (accept),
        .req_write(req_write),
        .gap_ok   (gap_ok)
    );

    psc_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .be_act   (be_act),
        .drive_en (drive_en),
        .capture  (capture),
        .mem_dq_i (mem_dq_i),
        .mem_addr (mem_addr),
        .mem_ub_n (mem_ub_n),
        .mem_lb_n (mem_lb_n),
        .mem_dq_o (mem_dq_o),
        .mem_dq_oe(mem_dq_oe),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    // length of the current chip-enable-low run, saturating one past the cap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ce_run_q <= '0;
        else if (mem_ce_n)
            ce_run_q <= '0;
        else if (ce_run_q != CR_W'(CEMAX_CYC + 1))
            ce_run_q <= ce_run_q + CR_W'(1);
    end

    assert_ce_low_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_run_q <= CR_W'(CEMAX_CYC));

    assert_single_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

endmodule

// File: tb/psram_async_ctrl_test.sv
module psram_async_ctrl_test;

    localparam int CLK_NS = 8;
    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    localparam int ACC_E   = cdiv(70);
    localparam int CYC_E   = cdiv(80);
    localparam int WP_E    = cdiv(75);
    localparam int REC_E   = cdiv(15);
    localparam int CPH_E   = cdiv(15);
    localparam int HZ_E    = cdiv(20);
    localparam int CEMAX_E = 1000 / CLK_NS;
    localparam int WREC_E  = (CYC_E - WP_E - 1 > REC_E) ? (CYC_E - WP_E - 1) : REC_E;
    localparam int TURN_E  = (HZ_E > CPH_E) ? HZ_E : CPH_E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i = 16'hF00F;

    always #(CLK_NS / 2) clk = ~clk;

    psram_async_ctrl #(
        .ADDR_W(20), .DATA_W(16), .ACC_CYC(ACC_E), .CYC_CYC(CYC_E), .WP_CYC(WP_E),
        .REC_CYC(REC_E), .CPH_CYC(CPH_E), .HZ_CYC(HZ_E), .CEMAX_CYC(CEMAX_E)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    logic [15:0] model_mem [int];
    logic [15:0] shadow    [int];

    // operation currently in flight, set right after its accepting edge
    bit          cur_wr = 1'b0;
    logic [1:0]  cur_be = 2'b00;
    logic [19:0] cur_addr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] rd_word(input logic [15:0] m [int], input int a);
        return m.exists(a) ? m[a] : 16'h0000;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // cycle monitor and memory model, both sampled mid-cycle
    int   ce_lo = 0, ce_hi = 100, oe_lo = 0, we_lo = 0, post_we = 0, since_oe = 100;
    bit   prev_ce_n = 1'b1, prev_oe_n = 1'b1, prev_we_n = 1'b1, prev_dq_oe = 1'b0;
    bit   last_rd = 1'b0, rd_bad = 1'b0, wr_bad = 1'b0, hold_bad = 1'b0;
    int   acnt = 0;
    logic [15:0] lat_d;
    logic [1:0]  lat_be;
    int          lat_a;

    always @(negedge clk) begin
        if (rst_n) begin
            // chip enable runs (R4, R7, R8, R9, R10)
            if (!mem_ce_n) begin
                if (prev_ce_n) begin
                    chk(ce_hi >= CPH_E + 1, "R7 ce high gap", ce_hi, CPH_E + 1);
                    if (cur_wr && last_rd)
                        chk(ce_hi >= TURN_E + 1, "R8 read-to-write gap", ce_hi, TURN_E + 1);
                    if (cur_wr)
                        chk(mem_oe_n, "R9 oe high at write address", int'(mem_oe_n), 1);
                end
                ce_lo++;
            end else begin
                if (!prev_ce_n) begin
                    chk(ce_lo >= CYC_E, "R4 ce low cycle time", ce_lo, CYC_E);
                    chk(ce_lo <= CEMAX_E, "R10 ce low cap", ce_lo, CEMAX_E);
                    last_rd = !cur_wr;
                    ce_hi = 1;
                end else begin
                    ce_hi++;
                end
                ce_lo = 0;
            end
            // read strobes (R2, R4)
            if (!mem_oe_n) begin
                oe_lo++;
                since_oe = 0;
                if (!mem_we_n || mem_ce_n || mem_lb_n != !cur_be[0] || mem_ub_n != !cur_be[1])
                    rd_bad = 1'b1;
            end else begin
                if (!prev_oe_n) begin
                    chk(oe_lo == ACC_E, "R4 oe low length", oe_lo, ACC_E);
                    chk(!rd_bad, "R2 read strobes", int'(rd_bad), 0);
                    rd_bad = 1'b0;
                end
                oe_lo = 0;
                since_oe++;
            end
            // write pulse (R5, R6, R9)
            if (!mem_we_n) begin
                we_lo++;
                if (!mem_dq_oe || !mem_oe_n || mem_lb_n != !cur_be[0] || mem_ub_n != !cur_be[1])
                    wr_bad = 1'b1;
                lat_d = mem_dq_o; lat_be = {!mem_ub_n, !mem_lb_n}; lat_a = int'(mem_addr);
            end else if (!prev_we_n) begin
                chk(we_lo == WP_E, "R5 write pulse length", we_lo, WP_E);
                chk(!wr_bad, "R5 write strobes and drive", int'(wr_bad), 0);
                chk(mem_ce_n, "R6 we and ce rise together", int'(mem_ce_n), 1);
                wr_bad = 1'b0;
                we_lo = 0;
                post_we = 0;
                if (lat_be[0]) model_mem[lat_a][7:0]  = lat_d[7:0];
                if (lat_be[1]) model_mem[lat_a][15:8] = lat_d[15:8];
                if (!model_mem.exists(lat_a)) model_mem[lat_a] = 16'h0000;
            end
            if (mem_dq_oe && mem_we_n) begin
                post_we++;
                if (mem_addr != cur_addr || mem_dq_o != lat_d) hold_bad = 1'b1;
            end
            if (!mem_dq_oe && prev_dq_oe) begin
                chk(post_we == WREC_E, "R6 recovery hold length", post_we, WREC_E);
                chk(!hold_bad, "R6 address and data held", int'(hold_bad), 0);
                hold_bad = 1'b0;
            end
            // drivers (R8)
            if (mem_dq_oe && !prev_dq_oe)
                chk(since_oe > HZ_E, "R8 float time before drive", since_oe, HZ_E + 1);
            if (mem_dq_oe && !mem_oe_n)
                chk(1'b0, "R8 driver while oe low", 1, 0);
            prev_ce_n = mem_ce_n; prev_oe_n = mem_oe_n; prev_we_n = mem_we_n; prev_dq_oe = mem_dq_oe;
            // model output: valid only after the full access wait
            if (!mem_ce_n && !mem_oe_n && mem_we_n) acnt++; else acnt = 0;
            if (acnt >= ACC_E) begin
                logic [15:0] w;
                w = rd_word(model_mem, int'(mem_addr));
                mem_dq_i = { mem_ub_n ? 8'hC3 : w[15:8], mem_lb_n ? 8'hC3 : w[7:0] };
            end else begin
                mem_dq_i = 16'hF00F;
            end
        end
    end

    task automatic do_op(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        int acc_cyc;
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        acc_cyc = cyc;
        cur_wr = wr; cur_be = be; cur_addr = a;
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d; req_be = ~be;   // later changes must be ignored (R11)
        @(negedge clk);
        chk(!req_ready, "R11 ready low while busy", int'(req_ready), 0);
        if (wr) begin
            logic [15:0] s;
            s = rd_word(shadow, int'(a));
            if (be[0]) s[7:0]  = d[7:0];
            if (be[1]) s[15:8] = d[15:8];
            shadow[int'(a)] = s;
        end else begin
            logic [15:0] s, e;
            while (!rsp_valid) @(negedge clk);
            chk(cyc - acc_cyc == ACC_E, "R2 read latency", cyc - acc_cyc, ACC_E);
            s = rd_word(shadow, int'(a));
            e = { be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00 };
            chk(rsp_rdata == e, "R3 read data with lane mask", int'(rsp_rdata), int'(e));
            @(negedge clk);
            chk(!rsp_valid, "R2 single valid pulse", int'(rsp_valid), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'h1F, "R1 strobes in reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} == 5'h1F, "R1 strobes after reset",
            int'({mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1F);
        chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 drive, valid and ready after reset",
            int'({mem_dq_oe, rsp_valid, req_ready}), 1);

        // directed: word, each byte lane, masked reads, top address, turnarounds
        do_op(1'b1, 20'h00000, 16'h1234, 2'b11);
        do_op(1'b0, 20'h00000, 16'h0000, 2'b11);
        do_op(1'b1, 20'h00000, 16'hFFAB, 2'b01);   // R5 lower lane only
        do_op(1'b0, 20'h00000, 16'h0000, 2'b11);
        do_op(1'b1, 20'h00000, 16'hCD00, 2'b10);   // R5 upper lane only
        do_op(1'b0, 20'h00000, 16'h0000, 2'b11);
        do_op(1'b0, 20'h00000, 16'h0000, 2'b01);   // R3 upper lane zero
        do_op(1'b0, 20'h00000, 16'h0000, 2'b10);   // R3 lower lane zero
        do_op(1'b1, 20'hFFFFF, 16'hBEEF, 2'b11);
        do_op(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
        do_op(1'b1, 20'hFFFFF, 16'h5555, 2'b11);   // R8 write straight after read
        do_op(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
        do_op(1'b0, 20'h00000, 16'h0000, 2'b11);   // back-to-back reads

        for (int i = 0; i < 120; i++) begin
            logic [19:0] a;
            logic [1:0]  be;
            int sel;
            sel = int'($urandom % 4);
            case (sel)
                0: a = 20'h00000;
                1: a = 20'hFFFFF;
                2: a = 20'h12345;
                default: a = 20'h00010 + 20'($urandom % 8);
            endcase
            be = 2'($urandom % 3) + 2'd1;
            do_op(1'($urandom % 2), a, 16'($urandom), be);
        end
        repeat (20) @(negedge clk);
        chk(mem_ce_n && !mem_dq_oe && req_ready, "R11 idle at end", int'({mem_ce_n, mem_dq_oe, req_ready}), 5);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule